// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frame bytes into host memory by walking a circular chain of receive descriptors. Each descriptor occupies four consecutive 32-bit words: a link to the following descriptor at byte offset 0, a status word at offset 4, a buffer byte address at offset 8 and a buffer length word at offset 12. The engine reads a descriptor's status first. A clear completion bit means the host has handed the descriptor over. The engine then reads the buffer address, the buffer length and the link. It stores the bytes of the next frame from its byte-stream input into that buffer, writes a completion status back, and moves along the link.

A descriptor whose completion bit is still set belongs to the host. The engine does not write to it. Instead it re-reads that status word after a programmable delay, counted in 30 ns units of `TICKS_PER_UNIT` clock cycles each. The host gives a descriptor back by zeroing its status word and rewriting its length word. The host loads the chain head while reception is off. Turning reception on starts a fetch at that head.

The memory port is a single-cycle port addressed in 32-bit words with per-byte write enables. Read data is valid on the cycle after the request.

Top module: `rxRingDma`

## Requirements
- R1: After a descriptor is chosen, the engine issues word reads at descriptor byte offsets 4 (status), then 8 (buffer address), then 12 (length), then 0 (link), in that order and on consecutive cycles.
- R2: Frame byte i is written to byte address buffer address + i, at any alignment. Each write is one word write with a single byte enable, selected by address bits 1:0.
- R3: At the end of a frame the status word is written with bit 15 set, the stored byte count in bits 12:0, and all other bits zero unless R4 applies.
- R4: The buffer size is bits 12:0 of the length word. Bytes beyond the buffer size are accepted but not written. The status then carries bit 16 set and a count equal to the buffer size.
- R5: After the status write-back, the next descriptor used is the one named by the link word, so the chain wraps back to its first descriptor.
- R6: A descriptor whose status bit 15 is set is neither written nor used to accept bytes.
- R7: While the engine waits on such a descriptor, successive reads of its status word are spaced exactly P*TICKS_PER_UNIT+3 cycles apart, where P is the 8-bit poll period (P=0 gives 3).
- R8: Once the host clears the status word of a waited-on descriptor, the engine's next poll takes it and the next frame lands in its buffer.
- R9: `rxDone` is high for exactly one cycle, the cycle after each status write, and the written status is already in memory then.
- R10: With reception off and the engine idle or polling, no memory access is made. Turning reception on from idle makes the next access a status read of the descriptor at `listHead`.
- R11: During and right after reset, `memReq`, `inReady` and `rxDone` are low.
- R12: `inReady` is high only while the engine holds a free descriptor and is taking frame bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxEn | input | 1 | Reception enable |
| listHead | input | AW | Byte address of the first descriptor to use |
| pollPeriod | input | 8 | Re-poll delay in 30 ns units |
| inValid | input | 1 | Frame byte present |
| inData | input | 8 | Frame byte |
| inLast | input | 1 | Marks the final byte of a frame |
| inReady | output | 1 | Engine takes a byte this cycle if inValid |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | AW-2 | Word address |
| memBe | output | 4 | Byte enables for writes |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| rxDone | output | 1 | One-cycle pulse after each status write-back |

## Verification
The bench sweeps frame lengths against three buffers of different sizes, one of them unaligned. The lengths include exact fits, overruns by one byte and short frames. A design that miscounts the limit would either overwrite the sentinel byte after the buffer or report a wrong length or truncation flag. The bench holds the ring full and measures the spacing of status re-reads at several poll periods, including zero. An off-by-one in the delay counter shows up as a wrong gap, and a design that ignores the ownership bit would write into a host-held descriptor. The bench also turns reception off while the engine polls and restarts it at a different head, which catches an engine that keeps fetching or resumes from its old position.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  typedef enum logic [2:0] {
    OP_NONE, OP_RD_STAT, OP_RD_ADDR, OP_RD_LEN, OP_RD_NEXT, OP_WR_BYTE, OP_WR_STAT
  } memop_e;

  typedef struct packed {
    memop_e op;
    logic   ldHead;
    logic   capAddr;
    logic   capLen;
    logic   capNext;
    logic   advance;
    logic   frameClr;
    logic   dropByte;
  } ctl_s;

  localparam int DONE_BIT  = 15;
  localparam int TRUNC_BIT = 16;
  localparam int CNT_BITS  = 13;
  localparam int OFS_NEXT  = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_ADDR  = 2;
  localparam int OFS_LEN   = 3;
endpackage

// File: rtl/rxdma_dp.sv
module rxdma_dp
  import rxdma_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_s                  ctl,
  input  logic [AW-1:0]         listHead,
  input  logic [31:0]           memRdata,
  input  logic [7:0]            inData,
  output logic                  memReq,
  output logic                  memWe,
  output logic [AW-3:0]         memAddr,
  output logic [3:0]            memBe,
  output logic [31:0]           memWdata,
  output logic                  descBusy,
  output logic                  roomLeft,
  output logic                  frameIdle
);
  localparam int WA = AW - 2;

  logic [WA-1:0]       curDesc;
  logic [WA-1:0]       nextPtr;
  logic [AW-1:0]       bufAddr;
  logic [CNT_BITS-1:0] bufSize;
  logic [CNT_BITS-1:0] byteCnt;
  logic                trunc;
  logic [AW-1:0]       byteAddr;
  logic [31:0]         statWord;

  assign byteAddr  = bufAddr + AW'(byteCnt);
  assign roomLeft  = byteCnt < bufSize;
  assign frameIdle = (byteCnt == '0) && !trunc;
  assign descBusy  = memRdata[DONE_BIT];

  always_comb begin
    statWord = '0;
    statWord[DONE_BIT] = 1'b1;
    statWord[TRUNC_BIT] = trunc;
    statWord[CNT_BITS-1:0] = byteCnt;
  end

  always_comb begin
    memReq   = ctl.op != OP_NONE;
    memWe    = 1'b0;
    memAddr  = curDesc;
    memBe    = 4'h0;
    memWdata = '0;
    unique case (ctl.op)
      OP_RD_STAT: memAddr = curDesc + WA'(OFS_STAT);
      OP_RD_ADDR: memAddr = curDesc + WA'(OFS_ADDR);
      OP_RD_LEN:  memAddr = curDesc + WA'(OFS_LEN);
      OP_RD_NEXT: memAddr = curDesc + WA'(OFS_NEXT);
      OP_WR_BYTE: begin
        memWe    = 1'b1;
        memAddr  = byteAddr[AW-1:2];
        memBe    = 4'b0001 << byteAddr[1:0];
        memWdata = {4{inData}};
      end
      OP_WR_STAT: begin
        memWe    = 1'b1;
        memAddr  = curDesc + WA'(OFS_STAT);
        memBe    = 4'hF;
        memWdata = statWord;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curDesc <= '0;
      nextPtr <= '0;
      bufAddr <= '0;
      bufSize <= '0;
      byteCnt <= '0;
      trunc   <= 1'b0;
    end else begin
      if (ctl.ldHead)  curDesc <= listHead[AW-1:2];
      if (ctl.advance) curDesc <= nextPtr;
      if (ctl.capAddr) bufAddr <= memRdata[AW-1:0];
      if (ctl.capLen)  bufSize <= memRdata[CNT_BITS-1:0];
      if (ctl.capNext) nextPtr <= memRdata[AW-1:2];
      if (ctl.frameClr) begin
        byteCnt <= '0;
        trunc   <= 1'b0;
      end else begin
        if (ctl.op == OP_WR_BYTE) byteCnt <= byteCnt + 1'b1;
        if (ctl.dropByte)         trunc   <= 1'b1;
      end
    end
  end

  // R4: a buffer write never lands beyond the buffer size
  p_in_buffer_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.op == OP_WR_BYTE |-> byteCnt < bufSize);
  // R4: a truncated frame reports a count equal to the buffer size
  p_trunc_len_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.op == OP_WR_STAT && memWdata[TRUNC_BIT]) |-> memWdata[CNT_BITS-1:0] == bufSize);
  // R3: the reported count never exceeds the buffer
  p_len_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.op == OP_WR_STAT |-> memWdata[CNT_BITS-1:0] <= bufSize);
endmodule

// File: rtl/rxdma_ctrl.sv
module rxdma_ctrl
  import rxdma_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 6,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxEn,
  input  logic [PW-1:0] pollPeriod,
  input  logic          inValid,
  input  logic          inLast,
  input  logic          descBusy,
  input  logic          roomLeft,
  input  logic          frameIdle,
  output ctl_s          ctl,
  output logic          inReady,
  output logic          rxDone
);
  localparam int CW = PW + $clog2(TICKS_PER_UNIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_STAT, S_CHK, S_GOT_ADDR, S_GOT_LEN, S_GOT_NEXT,
    S_DATA, S_WB, S_ADV, S_POLL
  } state_e;

  state_e         st, nxt;
  logic [CW-1:0]  pollCnt;

  assign inReady = st == S_DATA;
  assign rxDone  = st == S_ADV;

  always_comb begin
    nxt = st;
    ctl = '0;
    ctl.op = OP_NONE;
    unique case (st)
      S_IDLE: if (rxEn) begin
        ctl.ldHead = 1'b1;
        nxt = S_RD_STAT;
      end
      S_RD_STAT: begin
        ctl.op = OP_RD_STAT;
        nxt = S_CHK;
      end
      S_CHK: begin
        if (!rxEn)         nxt = S_IDLE;
        else if (descBusy) nxt = S_POLL;
        else begin
          ctl.op = OP_RD_ADDR;
          nxt = S_GOT_ADDR;
        end
      end
      S_GOT_ADDR: begin
        ctl.capAddr = 1'b1;
        ctl.op = OP_RD_LEN;
        nxt = S_GOT_LEN;
      end
      S_GOT_LEN: begin
        ctl.capLen = 1'b1;
        ctl.op = OP_RD_NEXT;
        nxt = S_GOT_NEXT;
      end
      S_GOT_NEXT: begin
        ctl.capNext  = 1'b1;
        ctl.frameClr = 1'b1;
        nxt = S_DATA;
      end
      S_DATA: begin
        if (inValid) begin
          if (roomLeft) ctl.op = OP_WR_BYTE;
          else          ctl.dropByte = 1'b1;
          if (inLast)   nxt = S_WB;
        end else if (!rxEn && frameIdle) nxt = S_IDLE;
      end
      S_WB: begin
        ctl.op = OP_WR_STAT;
        nxt = S_ADV;
      end
      S_ADV: begin
        ctl.advance = 1'b1;
        nxt = rxEn ? S_RD_STAT : S_IDLE;
      end
      S_POLL: begin
        if (!rxEn)              nxt = S_IDLE;
        else if (pollCnt == '0) nxt = S_RD_STAT;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st      <= S_IDLE;
      pollCnt <= '0;
    end else begin
      st <= nxt;
      if (st == S_CHK)                         pollCnt <= CW'(pollPeriod) * CW'(TICKS_PER_UNIT);
      else if (st == S_POLL && pollCnt != '0)  pollCnt <= pollCnt - 1'b1;
    end
  end

  // R9: the done pulse follows a status write
  p_done_after_wb_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> $past(ctl.op == OP_WR_STAT));
  // R9: the pulse lasts one cycle
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone);
  // R6: a host-owned descriptor sends the engine to wait
  p_busy_waits_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_CHK && rxEn && descBusy) |=> (st == S_POLL && !inReady));
  // R7: the poll delay counts down by one each cycle
  p_poll_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_POLL && rxEn && pollCnt != '0) |=> pollCnt == $past(pollCnt) - 1'b1);
  // R10: enabling from idle fetches a status word next
  p_start_fetch_r10: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_IDLE && rxEn) |=> ctl.op == OP_RD_STAT);
endmodule

// File: rtl/rxRingDma.sv
module rxRingDma
  import rxdma_pkg::*;
#(
  parameter int AW = 32,
  parameter int TICKS_PER_UNIT = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxEn,
  input  logic [AW-1:0] listHead,
  input  logic [7:0]    pollPeriod,
  input  logic          inValid,
  input  logic [7:0]    inData,
  input  logic          inLast,
  output logic          inReady,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-3:0] memAddr,
  output logic [3:0]    memBe,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          rxDone
);
  ctl_s ctl;
  logic descBusy, roomLeft, frameIdle;

  rxdma_ctrl #(.TICKS_PER_UNIT(TICKS_PER_UNIT), .PW(8)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .pollPeriod(pollPeriod),
    .inValid(inValid), .inLast(inLast), .descBusy(descBusy),
    .roomLeft(roomLeft), .frameIdle(frameIdle),
    .ctl(ctl), .inReady(inReady), .rxDone(rxDone)
  );

  rxdma_dp #(.AW(AW)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .listHead(listHead),
    .memRdata(memRdata), .inData(inData),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memBe(memBe),
    .memWdata(memWdata), .descBusy(descBusy), .roomLeft(roomLeft),
    .frameIdle(frameIdle)
  );

  // R12: single-byte writes only happen for an accepted input byte
  p_byte_accepted_r12: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe != 4'hF) |-> (inReady && inValid));
  // R2: a byte write enables exactly one lane
  p_one_lane_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && inReady) |-> $onehot0(memBe) && memBe != 4'h0);
endmodule

// File: tb/test_rxRingDma.sv
module test_rxRingDma;
  localparam int AW = 32;
  localparam int TPU = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEn = 1'b0;
  logic [AW-1:0] listHead = '0;
  logic [7:0] pollPeriod = 8'd2;
  logic inValid = 1'b0;
  logic [7:0] inData = '0;
  logic inLast = 1'b0;
  logic inReady, memReq, memWe, rxDone;
  logic [AW-3:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;

  always #2.5 clk = ~clk;

  rxRingDma #(.AW(AW), .TICKS_PER_UNIT(TPU)) i_rxRingDma (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .listHead(listHead),
    .pollPeriod(pollPeriod), .inValid(inValid), .inData(inData),
    .inLast(inLast), .inReady(inReady), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .rxDone(rxDone)
  );

  logic [31:0] mem [0:1023];
  always @(posedge clk) begin
    if (memReq) begin
      if (memWe) begin
        for (int b = 0; b < 4; b++)
          if (memBe[b]) mem[memAddr[9:0]][8*b +: 8] <= memWdata[8*b +: 8];
      end else memRdata <= mem[memAddr[9:0]];
    end
  end

  int nChecks = 0, nFails = 0;
  int cyc = 0;
  int wrCnt = 0, readyCnt = 0, reqCnt = 0, statHits = 0;
  int statT = 0, statPrev = 0;
  logic [AW-3:0] watchAddr = 30'h41;
  logic [AW-3:0] readLog [0:7];
  int readN = 0;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (memWe) wrCnt <= wrCnt + 1;
    if (inReady) readyCnt <= readyCnt + 1;
    if (memReq) reqCnt <= reqCnt + 1;
    if (memReq && !memWe) begin
      if (readN < 8) readLog[readN] <= memAddr;
      readN <= readN + 1;
      if (memAddr == watchAddr) begin
        statPrev <= statT;
        statT <= cyc;
        statHits <= statHits + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int tag, input int i);
    return 8'((tag * 37 + i * 5 + 1) & 255);
  endfunction

  function automatic logic [7:0] getByte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  int descBase [3] = '{32'h100, 32'h110, 32'h120};
  int bufBase  [3] = '{32'h400, 32'h502, 32'h600};
  int bufSz    [3] = '{16, 7, 40};

  task automatic fillSentinel();
    for (int w = 32'h100; w < 32'h1C0; w++) mem[w] = 32'hA5A5A5A5;
  endtask

  task automatic giveBack(input int d);
    mem[(descBase[d] >> 2) + 1] = 32'h0;
    mem[(descBase[d] >> 2) + 3] = 32'h8000_0000 | bufSz[d];
  endtask

  task automatic sendFrame(input int len, input int tag);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      inValid = 1'b1;
      inData = pat(tag, i);
      inLast = (i == len - 1);
      while (!inReady) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast = 1'b0;
  endtask

  task automatic frameCheck(input int d, input int len, input int tag);
    int stored;
    logic [31:0] expStat;
    bit bytesOk;
    stored = (len > bufSz[d]) ? bufSz[d] : len;
    expStat = 32'h8000 | ((len > bufSz[d]) ? 32'h10000 : 32'h0) | 32'(stored);
    sendFrame(len, tag);
    while (!rxDone) @(negedge clk);
    // R9 and R3/R4: status is in memory while the pulse is high
    chk(mem[(descBase[d] >> 2) + 1] == expStat, "R3/R4/R9 status word",
        mem[(descBase[d] >> 2) + 1], expStat);
    bytesOk = 1'b1;
    for (int i = 0; i < stored; i++)
      if (getByte(bufBase[d] + i) != pat(tag, i)) bytesOk = 1'b0;
    chk(bytesOk, "R2 buffer bytes", 32'(bytesOk), 32'd1);
    // R4: the byte after the stored data is untouched
    chk(getByte(bufBase[d] + stored) == 8'hA5, "R4 byte past data untouched",
        32'(getByte(bufBase[d] + stored)), 32'hA5);
    @(negedge clk);
    chk(rxDone == 1'b0, "R9 single-cycle pulse", 32'(rxDone), 32'd0);
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    wait (cyc == 150000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected completion", cyc);
    finish();
  end

  initial begin
    int w0, r0, q0;
    for (int w = 0; w < 1024; w++) mem[w] = 32'h0;
    fillSentinel();
    for (int d = 0; d < 3; d++) begin
      mem[descBase[d] >> 2] = descBase[(d + 1) % 3];
      mem[(descBase[d] >> 2) + 2] = bufBase[d];
      giveBack(d);
    end
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(memReq == 1'b0, "R11 memReq in reset", 32'(memReq), 0);
    chk(inReady == 1'b0, "R11 inReady in reset", 32'(inReady), 0);
    chk(rxDone == 1'b0, "R11 rxDone in reset", 32'(rxDone), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk(memReq == 1'b0 && inReady == 1'b0, "R10 idle while disabled", 32'(memReq), 0);
    listHead = 32'h100;
    readN = 0;
    rxEn = 1'b1;
    repeat (8) @(negedge clk);
    // R1 / R10: fetch order starting at the head descriptor
    chk(readLog[0] == 30'h41, "R10 R1 first read is head status", 32'(readLog[0]), 32'h41);
    chk(readLog[1] == 30'h42, "R1 buffer address read", 32'(readLog[1]), 32'h42);
    chk(readLog[2] == 30'h43, "R1 length read", 32'(readLog[2]), 32'h43);
    chk(readLog[3] == 30'h40, "R1 link read", 32'(readLog[3]), 32'h40);
    chk(inReady == 1'b1, "R12 ready with free descriptor", 32'(inReady), 1);

    for (int r = 0; r < 6; r++) begin
      if (r > 0) begin
        @(negedge clk);
        fillSentinel();
        for (int d = 0; d < 3; d++) giveBack(d); // R8 host return
      end
      for (int d = 0; d < 3; d++) begin
        int len;
        if (r == 0) len = bufSz[d];
        else if (r == 1) len = bufSz[d] + 1;
        else len = 1 + ((r * 13 + d * 7) % (bufSz[d] + 3));
        frameCheck(d, len, r * 3 + d);
      end
      if (r == 0) begin
        q0 = statHits;
        w0 = wrCnt;
        r0 = readyCnt;
        repeat (60) @(negedge clk);
        chk(statHits > q0, "R5 wrap back to first descriptor", 32'(statHits), 32'(q0 + 1));
        chk(statT - statPrev == 2 * TPU + 3, "R7 gap period 2", 32'(statT - statPrev), 32'(2 * TPU + 3));
        pollPeriod = 8'd0;
        repeat (30) @(negedge clk);
        chk(statT - statPrev == 3, "R7 gap period 0", 32'(statT - statPrev), 32'd3);
        pollPeriod = 8'd5;
        repeat (90) @(negedge clk);
        chk(statT - statPrev == 5 * TPU + 3, "R7 gap period 5", 32'(statT - statPrev), 32'(5 * TPU + 3));
        chk(wrCnt == w0, "R6 no write to owned descriptor", 32'(wrCnt), 32'(w0));
        chk(readyCnt == r0, "R6 R12 no ready while owned", 32'(readyCnt), 32'(r0));
        pollPeriod = 8'd1;
      end
    end

    // R10: disable while polling, restart at a new head
    repeat (20) @(negedge clk);
    rxEn = 1'b0;
    repeat (10) @(negedge clk);
    q0 = reqCnt;
    repeat (30) @(negedge clk);
    chk(reqCnt == q0, "R10 no access while disabled", 32'(reqCnt), 32'(q0));
    fillSentinel();
    giveBack(1);
    listHead = 32'h110;
    readN = 0;
    rxEn = 1'b1;
    repeat (8) @(negedge clk);
    chk(readLog[0] == 30'h45, "R10 restart at new head", 32'(readLog[0]), 32'h45);
    frameCheck(1, 3, 99);
    finish();
  end
endmodule